// File: doc/BRIEF.md
# E1 Multiframe Overhead Bit Inserter

This block sits in the line-to-PCM path of a 2.048 Mbit/s E1 stream and overwrites the spare and alarm overhead bits of timeslot 0 with values held in software-written registers. Inputs are the serial data, a bit clock enable, a marker on the first bit of every frame and a marker on the first bit of every 16-frame multiframe. The output is the same serial stream. Overhead positions carry the register values. Every other bit passes through in the same cycle.

Software writes a pending register set through a simple write port. The pending set is copied into the active set only when the multiframe marker is accepted. A multiframe therefore always carries one consistent set of values. Counters keep track of the frame and bit position between markers. A new multiframe marker forces the frame count back to zero, so a stream that realigns is followed at once. Until the first multiframe marker is seen after reset, and whenever the enable input is low, the stream passes unchanged.

Top module: `e1_ovh_insert`

## Requirements
- R1: On an odd frame, timeslot-0 bit 1 (the first bit of the frame) carries the E1 value in frame 13 and the E2 value in frame 15. In every other odd frame this bit passes through. The E values sit in the control register at address 5: bit 0 is E1 and bit 1 is E2.
- R2: Timeslot-0 bit 3 of every odd frame carries the A value, which is bit 2 of the control register at address 5.
- R3: Timeslot-0 bits 4 to 8 of odd frame 2k+1 carry bit k of the spare-bit registers at addresses 0 to 4, in that order. Address 0 feeds bit 4 and address 4 feeds bit 8.
- R4: Even frames, timeslot-0 bit 2 and all bits of timeslots 1 to 31 leave with the input value, combinationally and in the same cycle.
- R5: A write goes to the pending set only. The active set is loaded from the pending set at the clock edge where the bit enable and the multiframe marker are both high. A write in that same cycle takes effect one multiframe later.
- R6: With the enable input low, every output bit equals the input bit. Position tracking and register loading continue while the enable is low.
- R7: After reset, the block passes every bit until the first multiframe marker. The pending and active values are all zero.
- R8: The position advances only on cycles with the bit enable high. The frame marker restarts the bit count. The multiframe marker forces frame 0 even when the previous multiframe was short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Insertion enable; low means full bypass |
| bit_en | input | 1 | High on cycles that carry a stream bit |
| sdi | input | 1 | Serial data in |
| frm_start | input | 1 | Marks bit 1 of every frame |
| mf_start | input | 1 | Marks bit 1 of frame 0 of a multiframe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0..4 spare bits 4..8, 5 control |
| wr_data | input | 8 | Register write data |
| sdo | output | 1 | Serial data out |

## Verification
The stream is driven with all-zero, all-one and pseudo-random data. An inserted bit can then be told apart from a passed-through bit in both polarities. It can also be told apart from a bit shifted to a neighbouring position. Spare-bit registers hold distinct byte patterns, so a wrong frame-to-bit-index mapping or a swapped address shows up in at least one frame. Writes are placed in the middle of a multiframe, on the boundary cycle and while bypassed. These cases separate correct boundary loading from immediate or late loading. Runs with idle bit-enable gaps and a short multiframe show whether the position counters hold between bits and realign on the marker.

// File: rtl/e1_ovh_insert.sv
module e1_ovh_insert #(
  parameter int FRAME_BITS = 256,
  parameter int MF_FRAMES  = 16,
  parameter int ADDR_W     = 3,
  localparam int SA_W      = MF_FRAMES / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              bit_en,
  input  logic              sdi,
  input  logic              frm_start,
  input  logic              mf_start,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [SA_W-1:0]   wr_data,
  output logic              sdo
);
  localparam int BW     = $clog2(FRAME_BITS);
  localparam int FW     = $clog2(MF_FRAMES);
  localparam int N_SA   = 5;
  localparam int E1_FRM = MF_FRAMES - 3;
  localparam int E2_FRM = MF_FRAMES - 1;

  logic [BW-1:0] pos_bit, cur_bit;
  logic [FW-1:0] pos_frm, cur_frm;
  logic          aligned, locked, last_bit;
  logic [N_SA-1:0][SA_W-1:0] pend_sa, act_sa;
  logic [2:0]    pend_ctl, act_ctl;
  logic          ins, ins_val;

  assign cur_bit  = (frm_start || mf_start) ? '0 : pos_bit;
  assign cur_frm  = mf_start ? '0 : pos_frm;
  assign locked   = aligned || mf_start;
  assign last_bit = (cur_bit == BW'(FRAME_BITS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_bit <= '0;
      pos_frm <= '0;
      aligned <= 1'b0;
    end else if (bit_en) begin
      pos_bit <= last_bit ? '0 : cur_bit + 1'b1;
      if (last_bit)
        pos_frm <= (cur_frm == FW'(MF_FRAMES - 1)) ? '0 : cur_frm + 1'b1;
      else
        pos_frm <= cur_frm;
      if (mf_start) aligned <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_sa  <= '0;
      pend_ctl <= '0;
      act_sa   <= '0;
      act_ctl  <= '0;
    end else begin
      if (bit_en && mf_start) begin
        act_sa  <= pend_sa;
        act_ctl <= pend_ctl;
      end
      if (wr_en) begin
        case (wr_addr)
          ADDR_W'(0): pend_sa[0] <= wr_data;
          ADDR_W'(1): pend_sa[1] <= wr_data;
          ADDR_W'(2): pend_sa[2] <= wr_data;
          ADDR_W'(3): pend_sa[3] <= wr_data;
          ADDR_W'(4): pend_sa[4] <= wr_data;
          ADDR_W'(5): pend_ctl   <= wr_data[2:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    ins     = 1'b0;
    ins_val = 1'b0;
    if (en && locked && cur_frm[0] && (cur_bit < BW'(8))) begin
      case (cur_bit[2:0])
        3'd0: begin
          if (cur_frm == FW'(E1_FRM)) begin
            ins     = 1'b1;
            ins_val = act_ctl[0];
          end else if (cur_frm == FW'(E2_FRM)) begin
            ins     = 1'b1;
            ins_val = act_ctl[1];
          end
        end
        3'd1: ins = 1'b0;
        3'd2: begin
          ins     = 1'b1;
          ins_val = act_ctl[2];
        end
        default: begin
          ins     = 1'b1;
          ins_val = act_sa[cur_bit[2:0] - 3'd3][cur_frm[FW-1:1]];
        end
      endcase
    end
  end

  assign sdo = ins ? ins_val : sdi;
endmodule

// File: rtl/e1_ovh_insert_chk.sv
module e1_ovh_insert_chk #(
  parameter int BW     = 8,
  parameter int FW     = 4,
  parameter int SA_W   = 8,
  parameter int E1_FRM = 13
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 en,
  input logic                 bit_en,
  input logic                 mf_start,
  input logic                 sdi,
  input logic                 sdo,
  input logic                 locked,
  input logic [BW-1:0]        cur_bit,
  input logic [FW-1:0]        cur_frm,
  input logic [BW-1:0]        pos_bit,
  input logic [2:0]           act_ctl,
  input logic [5*SA_W-1:0]    act_sa
);
  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> sdo == sdi); // R6
  AST_EVEN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_frm[0] |-> sdo == sdi); // R4
  AST_PAYLOAD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    cur_bit >= BW'(8) |-> sdo == sdi); // R4
  AST_UNLOCKED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> sdo == sdi); // R7
  AST_E1_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    en && locked && cur_frm == FW'(E1_FRM) && cur_bit == '0 |-> sdo == act_ctl[0]); // R1
  AST_A_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    en && locked && cur_frm[0] && cur_bit == BW'(2) |-> sdo == act_ctl[2]); // R2
  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_en && mf_start) |=> $stable(act_sa) && $stable(act_ctl)); // R5
  AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(pos_bit)); // R8
endmodule

bind e1_ovh_insert e1_ovh_insert_chk #(
  .BW(BW), .FW(FW), .SA_W(SA_W), .E1_FRM(E1_FRM)
) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .bit_en(bit_en), .mf_start(mf_start),
  .sdi(sdi), .sdo(sdo), .locked(locked), .cur_bit(cur_bit), .cur_frm(cur_frm),
  .pos_bit(pos_bit), .act_ctl(act_ctl), .act_sa(act_sa)
);

// File: tb/e1_ovh_insert_tb_top.sv
module e1_ovh_insert_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1, bit_en = 1'b0, sdi = 1'b0, frm_start = 1'b0, mf_start = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic sdo;

  int checks = 0;
  int failures = 0;

  logic [7:0] m_pend_sa [5];
  logic [7:0] m_act_sa  [5];
  logic [2:0] m_pend_ctl, m_act_ctl;
  bit         m_aligned;
  logic [15:0] lfsr = 16'hACE1;

  bit         sch_valid;
  int         sch_f, sch_b;
  logic [2:0] sch_addr;
  logic [7:0] sch_data;

  always #(CLK_PERIOD / 2) clk = ~clk;

  e1_ovh_insert dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .bit_en(bit_en), .sdi(sdi),
    .frm_start(frm_start), .mf_start(mf_start), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .sdo(sdo)
  );

  task automatic check(input logic got, input logic exp, input string tag, input string what);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: got=%0b expected=%0b", tag, what, got, exp);
    end
  endtask

  function automatic void model_write(input logic [2:0] a, input logic [7:0] d);
    if (a < 3'd5) m_pend_sa[a] = d;
    else if (a == 3'd5) m_pend_ctl = d[2:0];
  endfunction

  function automatic logic next_data(input int mode);
    if (mode == 0) return 1'b0;
    if (mode == 1) return 1'b1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic send_bit(input bit fs, input bit ms, input logic d, input int f, input int b,
                          input bit gap, input string phase);
    logic exp;
    string tag;
    bit hit;
    @(negedge clk);
    hit = sch_valid && f == sch_f && b == sch_b;
    bit_en = 1'b1; frm_start = fs; mf_start = ms; sdi = d;
    wr_en = hit; wr_addr = sch_addr; wr_data = sch_data;
    if (ms) begin
      for (int i = 0; i < 5; i++) m_act_sa[i] = m_pend_sa[i];
      m_act_ctl = m_pend_ctl;
      m_aligned = 1'b1;
    end
    exp = d;
    if (!en) tag = "R6";
    else if (!m_aligned) tag = "R7";
    else if (f % 2 == 0 || b >= 8 || b == 1) tag = "R4";
    else if (b == 0) begin
      tag = "R1";
      if (f == 13) exp = m_act_ctl[0];
      else if (f == 15) exp = m_act_ctl[1];
    end else if (b == 2) begin
      tag = "R2";
      exp = m_act_ctl[2];
    end else begin
      tag = "R3";
      exp = m_act_sa[b - 3][f / 2];
    end
    #1;
    check(sdo, exp, tag, $sformatf("%s frame %0d bit %0d", phase, f, b + 1));
    if (hit) begin
      model_write(sch_addr, sch_data);
      sch_valid = 1'b0;
    end
    if (gap) begin
      @(negedge clk);
      bit_en = 1'b0; frm_start = 1'b0; mf_start = 1'b0; wr_en = 1'b0;
      sdi = next_data(2);
    end
  endtask

  task automatic run_mf(input int nframes, input int mode, input bit gap, input string phase);
    for (int f = 0; f < nframes; f++)
      for (int b = 0; b < 256; b++)
        send_bit(b == 0, f == 0 && b == 0, next_data(mode), f, b, gap, phase);
  endtask

  task automatic write_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bit_en = 1'b0; frm_start = 1'b0; mf_start = 1'b0;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    model_write(a, d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic schedule(input int f, input int b, input logic [2:0] a, input logic [7:0] d);
    sch_valid = 1'b1; sch_f = f; sch_b = b; sch_addr = a; sch_data = d;
  endtask

  initial begin
    for (int i = 0; i < 5; i++) begin
      m_pend_sa[i] = '0;
      m_act_sa[i] = '0;
    end
    m_pend_ctl = '0; m_act_ctl = '0; m_aligned = 1'b0; sch_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    sdi = 1'b1; #1;
    check(sdo, 1'b1, "R7", "idle after reset, input 1");
    @(negedge clk);
    sdi = 1'b0; #1;
    check(sdo, 1'b0, "R7", "idle after reset, input 0");
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      bit_en = 1'b1; sdi = next_data(2); #1;
      check(sdo, sdi, "R7", "unaligned stream passes");
    end
    run_mf(16, 1, 1'b0, "R7 zero active after reset, ones");
    write_reg(3'd0, 8'hA5);
    write_reg(3'd1, 8'h3C);
    write_reg(3'd2, 8'h0F);
    write_reg(3'd3, 8'hF0);
    write_reg(3'd4, 8'h96);
    write_reg(3'd5, 8'h05);
    write_reg(3'd6, 8'hFF);
    run_mf(16, 0, 1'b0, "R5 pending not active yet, zeros");
    run_mf(16, 0, 1'b0, "zeros");
    run_mf(16, 1, 1'b0, "ones");
    run_mf(16, 2, 1'b0, "random");
    schedule(5, 100, 3'd5, 8'h02);
    run_mf(16, 2, 1'b0, "R5 mid-multiframe write held");
    schedule(0, 0, 3'd1, 8'hC3);
    run_mf(16, 1, 1'b0, "R5 boundary write held");
    run_mf(16, 0, 1'b0, "R5 boundary write active");
    schedule(2, 7, 3'd4, 8'h69);
    run_mf(16, 2, 1'b1, "R8 gaps between bits");
    run_mf(3, 2, 1'b0, "R8 short multiframe");
    run_mf(16, 2, 1'b0, "R8 realigned");
    en = 1'b0;
    schedule(9, 40, 3'd2, 8'h81);
    run_mf(16, 0, 1'b0, "R6 bypass zeros");
    run_mf(16, 1, 1'b0, "R6 bypass ones");
    en = 1'b1;
    run_mf(16, 2, 1'b0, "R6 after bypass, loading continued");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule